// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block decides which of seven programmable address windows claims an incoming bus transaction. A caller presents a request strobe with a 32-bit address and a command class (I/O or memory). One clock later the block reports whether a window hit, which window it was, whether the card-side cycle is to be a memory or an I/O access, and the data width and timing-set attributes that belong to that window.

Every window can play either role. After reset, windows 0 to 4 answer memory commands and present memory cycles, and windows 5 and 6 answer I/O commands and present I/O cycles. Setting a window's override bit hands both choices to two separate per-window bits. One bit selects the bus-side command class the window answers. The other selects the cycle class presented to the card. Memory-role and I/O-role windows use different matching rules.

Software programs the windows through a synchronous write port, using a register select and 16 bits of data. Windows should never overlap. If they do, the lowest-numbered window wins and a sticky error flag is raised.

Top module: `win_dec`

## Requirements
- R1: After reset, every window is disabled and every override bit is clear. `hit`, `hit_idx`, `card_is_mem`, `data_wide`, `timer_sel` and `overlap_err` are all zero, and a request does not hit.
- R2: Decode is registered. A request sampled at a clock edge drives its result on the outputs from that edge until the next one. With no request, or with no matching window, `hit` is 0 and `hit_idx`, `card_is_mem`, `data_wide` and `timer_sel` are 0.
- R3: A window whose enable bit is clear never claims a cycle.
- R4: An I/O-role window matches an I/O-class request only when address bits 31:16 are zero and bits 15:0 lie within [start, end] inclusive.
- R5: A memory-role window matches a memory-class request only when address bits 31:24 equal its 8-bit upper register and address bits 23:12 lie within [start[11:0], end[11:0]] inclusive. This gives 4 KB granularity, and the low 12 address bits do not affect the match.
- R6: With its override bit clear, window w (w < 5) answers memory-class requests only and presents a memory cycle (`card_is_mem`=1). Windows 5 and 6 answer I/O-class requests only and present I/O cycles (`card_is_mem`=0).
- R7: With its override bit set, the window's bus-side bit chooses the request class it answers (1 = memory, 0 = I/O), and that class's matching rule applies. The window's card-side bit independently sets `card_is_mem`.
- R8: On a hit, `timer_sel` equals bits 1:0 and `data_wide` equals bit 2 of the winning window's attribute register, whatever role the window has.
- R9: When several windows match, `hit_idx` names the lowest-numbered one. `overlap_err` rises on the same edge as that result and stays set until a write to select 4. When a clear and a new overlap fall on the same edge, the set wins.
- R10: A write sampled at a clock edge does not affect a request sampled at that same edge. It does affect every request sampled at a later edge.
- R11: Register selects are as follows. 0 is the enable vector, 1 the override vector, 2 the bus-side class vector, 3 the card-side class vector and 4 the overlap clear, with bit w of each vector belonging to window w. Window w's registers sit at 8+4w (start), 9+4w (end), 10+4w (upper, 8 bits) and 11+4w (attributes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 6 | Register select |
| wr_data | input | 16 | Register write data |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 32 | Transaction address |
| req_is_mem | input | 1 | Command class: 1 memory, 0 I/O |
| hit | output | 1 | A window claimed the request |
| hit_idx | output | 3 | Number of the claiming window |
| card_is_mem | output | 1 | Card cycle class: 1 memory, 0 I/O |
| data_wide | output | 1 | Window data width: 1 = 16-bit |
| timer_sel | output | 2 | Window timing-set selection |
| overlap_err | output | 1 | Sticky multiple-match flag |

## Verification
For every window, the address sweep probes one unit below the start, the start, the end and one unit above the end. It pairs each point with both command classes, a correct and a wrong upper or high address field, and, for memory windows, the lowest and highest byte of the 4 KB page. This separates off-by-one range comparisons, a missing command-class check, a missing upper-field or high-bits-zero check, and byte bits that leak into the page compare. The sweep runs again after overrides have swapped window roles, so that a role taken from the defaults rather than the override bits shows up as a wrong index or cycle class. Dedicated cases cover disabled windows, a write and a request on the same edge, and deliberately overlapping windows together with the sticky flag and its clear.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    localparam int NUM_WIN     = 7;
    localparam int NUM_MEM_DEF = 5;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 16;
    localparam int SEL_W       = 6;
    localparam int IDX_W       = $clog2(NUM_WIN);
    localparam int TMR_W       = 2;

    localparam int IO_W        = 16;
    localparam int PAGE_LSB    = 12;
    localparam int UPPER_LSB   = 24;
    localparam int PAGE_W      = UPPER_LSB - PAGE_LSB;
    localparam int UPPER_W     = ADDR_W - UPPER_LSB;

    localparam int SEL_ENABLE  = 0;
    localparam int SEL_OVR     = 1;
    localparam int SEL_BUS     = 2;
    localparam int SEL_CARD    = 3;
    localparam int SEL_CLR     = 4;
    localparam int WIN_BASE    = 8;
    localparam int WIN_STRIDE  = 4;
    localparam int OFS_START   = 0;
    localparam int OFS_END     = 1;
    localparam int OFS_UPPER   = 2;
    localparam int OFS_ATTR    = 3;

    typedef struct packed {
        logic [DATA_W-1:0]  start;
        logic [DATA_W-1:0]  stop;
        logic [UPPER_W-1:0] upper;
        logic [TMR_W-1:0]   timer;
        logic               wide;
    } win_cfg_t;

    typedef struct packed {
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic               card_mem;
        logic               wide;
        logic [TMR_W-1:0]   timer;
    } dec_out_t;

    function automatic logic [SEL_W-1:0] win_sel(input int w, input int ofs);
        return SEL_W'(WIN_BASE + w * WIN_STRIDE + ofs);
    endfunction

    function automatic logic in_range16(input logic [IO_W-1:0] v,
                                        input logic [IO_W-1:0] lo,
                                        input logic [IO_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import win_dec_pkg::*;
#(
    parameter int NWIN = NUM_WIN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NWIN-1:0]         map_en,
    output logic [NWIN-1:0]         type_ovr,
    output logic [NWIN-1:0]         bus_mem,
    output logic [NWIN-1:0]         card_mem,
    output win_cfg_t [NWIN-1:0]     cfg,
    output logic                    clr_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_en   <= '0;
            type_ovr <= '0;
            bus_mem  <= '0;
            card_mem <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_W'(SEL_ENABLE): map_en   <= wr_data[NWIN-1:0];
                SEL_W'(SEL_OVR):    type_ovr <= wr_data[NWIN-1:0];
                SEL_W'(SEL_BUS):    bus_mem  <= wr_data[NWIN-1:0];
                SEL_W'(SEL_CARD):   card_mem <= wr_data[NWIN-1:0];
                default: ;
            endcase
        end
    end

    assign clr_err = wr_en && (wr_sel == SEL_W'(SEL_CLR));

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [SEL_W-1:0] S_START = win_sel(w, OFS_START);
        localparam logic [SEL_W-1:0] S_END   = win_sel(w, OFS_END);
        localparam logic [SEL_W-1:0] S_UPPER = win_sel(w, OFS_UPPER);
        localparam logic [SEL_W-1:0] S_ATTR  = win_sel(w, OFS_ATTR);

        win_cfg_t r;

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (wr_en) begin
                if (wr_sel == S_START) r.start <= wr_data;
                if (wr_sel == S_END)   r.stop  <= wr_data;
                if (wr_sel == S_UPPER) r.upper <= wr_data[UPPER_W-1:0];
                if (wr_sel == S_ATTR) begin
                    r.timer <= wr_data[TMR_W-1:0];
                    r.wide  <= wr_data[TMR_W];
                end
            end
        end

        assign cfg[w] = r;
    end

endmodule

// File: rtl/win_match.sv
module win_match
    import win_dec_pkg::*;
#(
    parameter int WIN_IX  = 0,
    parameter int MEM_DEF = NUM_MEM_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_mem,
    input  logic              en,
    input  logic              ovr,
    input  logic              bus_mem_bit,
    input  logic              card_mem_bit,
    input  win_cfg_t          cfg,
    output logic              match,
    output logic              card_mem_o
);

    localparam logic DEF_MEM = (WIN_IX < MEM_DEF);

    logic                role_mem;
    logic                io_ok;
    logic                mem_ok;
    logic [PAGE_W-1:0]   page;
    logic [UPPER_W-1:0]  upper;
    logic [IO_W-1:0]     low16;

    assign role_mem   = ovr ? bus_mem_bit  : DEF_MEM;
    assign card_mem_o = ovr ? card_mem_bit : DEF_MEM;

    assign page  = addr[UPPER_LSB-1:PAGE_LSB];
    assign upper = addr[ADDR_W-1:UPPER_LSB];
    assign low16 = addr[IO_W-1:0];

    assign io_ok  = (addr[ADDR_W-1:IO_W] == '0)
                 && in_range16(low16, cfg.start, cfg.stop);

    assign mem_ok = (upper == cfg.upper)
                 && (page >= cfg.start[PAGE_W-1:0])
                 && (page <= cfg.stop[PAGE_W-1:0]);

    assign match = en && (is_mem == role_mem) && (role_mem ? mem_ok : io_ok);

endmodule

// File: rtl/win_prio.sv
module win_prio
    import win_dec_pkg::*;
#(
    parameter int NWIN = NUM_WIN
) (
    input  logic [NWIN-1:0]     match,
    input  logic [NWIN-1:0]     card_mem,
    input  win_cfg_t [NWIN-1:0] cfg,
    output dec_out_t            res,
    output logic                multi
);

    always_comb begin
        res = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                res.hit      = 1'b1;
                res.idx      = IDX_W'(w);
                res.card_mem = card_mem[w];
                res.wide     = cfg[w].wide;
                res.timer    = cfg[w].timer;
            end
        end
    end

    assign multi = (match & (match - 1'b1)) != '0;

endmodule

// File: rtl/win_dec.sv
module win_dec
    import win_dec_pkg::*;
#(
    parameter int NWIN    = NUM_WIN,
    parameter int MEM_DEF = NUM_MEM_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_is_mem,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx,
    output logic                card_is_mem,
    output logic                data_wide,
    output logic [TMR_W-1:0]    timer_sel,
    output logic                overlap_err
);

    logic [NWIN-1:0]     map_en;
    logic [NWIN-1:0]     type_ovr;
    logic [NWIN-1:0]     bus_mem;
    logic [NWIN-1:0]     card_mem;
    win_cfg_t [NWIN-1:0] cfg;
    logic                clr_err;

    logic [NWIN-1:0]     match;
    logic [NWIN-1:0]     card_sel;
    dec_out_t            res;
    logic                multi;

    dec_out_t            out_q;
    logic                ovl_q;

    win_cfg_regs #(.NWIN(NWIN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .map_en   (map_en),
        .type_ovr (type_ovr),
        .bus_mem  (bus_mem),
        .card_mem (card_mem),
        .cfg      (cfg),
        .clr_err  (clr_err)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_match
        win_match #(.WIN_IX(w), .MEM_DEF(MEM_DEF)) u_match (
            .addr         (req_addr),
            .is_mem       (req_is_mem),
            .en           (map_en[w]),
            .ovr          (type_ovr[w]),
            .bus_mem_bit  (bus_mem[w]),
            .card_mem_bit (card_mem[w]),
            .cfg          (cfg[w]),
            .match        (match[w]),
            .card_mem_o   (card_sel[w])
        );
    end

    win_prio #(.NWIN(NWIN)) u_prio (
        .match    (match),
        .card_mem (card_sel),
        .cfg      (cfg),
        .res      (res),
        .multi    (multi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            ovl_q <= 1'b0;
        end else begin
            out_q <= req_valid ? res : '0;
            if (req_valid && multi) begin
                ovl_q <= 1'b1;
            end else if (clr_err) begin
                ovl_q <= 1'b0;
            end
        end
    end

    assign hit         = out_q.hit;
    assign hit_idx     = out_q.idx;
    assign card_is_mem = out_q.card_mem;
    assign data_wide   = out_q.wide;
    assign timer_sel   = out_q.timer;
    assign overlap_err = ovl_q;

endmodule

// File: rtl/win_dec_chk.sv
module win_dec_chk
    import win_dec_pkg::*;
#(
    parameter int NWIN = NUM_WIN
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [SEL_W-1:0]   wr_sel,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_is_mem,
    input logic               hit,
    input logic [IDX_W-1:0]   hit_idx,
    input logic               card_is_mem,
    input logic               data_wide,
    input logic [TMR_W-1:0]   timer_sel,
    input logic               overlap_err,
    input logic [NWIN-1:0]    map_en
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!hit && hit_idx == '0 && !card_is_mem && !data_wide && timer_sel == '0)); // R2

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0 && !card_is_mem && !data_wide && timer_sel == '0)); // R2

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && map_en == '0) |=> !hit); // R3

    AST_IO_HIGH_BITS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_mem && req_addr[ADDR_W-1:IO_W] != '0) |=> !hit); // R4

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(hit_idx) < NWIN)); // R9

    AST_OVL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overlap_err && !(wr_en && wr_sel == SEL_W'(SEL_CLR))) |=> overlap_err); // R9

    AST_OVL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_W'(SEL_CLR) && !req_valid) |=> !overlap_err); // R9

endmodule

bind win_dec win_dec_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_is_mem  (req_is_mem),
    .hit         (hit),
    .hit_idx     (hit_idx),
    .card_is_mem (card_is_mem),
    .data_wide   (data_wide),
    .timer_sel   (timer_sel),
    .overlap_err (overlap_err),
    .map_en      (map_en)
);

// File: tb/sim_win_dec.sv
module sim_win_dec;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_mem = 1'b0;
    logic        hit;
    logic [2:0]  hit_idx;
    logic        card_is_mem;
    logic        data_wide;
    logic [1:0]  timer_sel;
    logic        overlap_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [6:0]  sh_en = '0, sh_ovr = '0, sh_bus = '0, sh_card = '0;
    logic [15:0] sh_start [NW];
    logic [15:0] sh_stop  [NW];
    logic [7:0]  sh_upper [NW];
    logic [2:0]  sh_attr  [NW];
    logic        exp_ovl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_dec u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_is_mem(req_is_mem),
        .hit(hit), .hit_idx(hit_idx), .card_is_mem(card_is_mem),
        .data_wide(data_wide), .timer_sel(timer_sel), .overlap_err(overlap_err)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    // Expected result built from R3..R9 and the shadow configuration
    task automatic model(input logic [31:0] a, input logic m,
                         output logic eh, output logic [2:0] ei, output logic ec,
                         output logic ew, output logic [1:0] et, output int n);
        eh = 0; ei = 0; ec = 0; ew = 0; et = 0; n = 0;
        for (int w = 0; w < NW; w++) begin
            logic rm, cm, ok;
            rm = sh_ovr[w] ? sh_bus[w]  : (w < 5);
            cm = sh_ovr[w] ? sh_card[w] : (w < 5);
            ok = 0;
            if (sh_en[w] && (m == rm)) begin
                if (rm)
                    ok = (a[31:24] == sh_upper[w]) && (a[23:12] >= sh_start[w][11:0])
                         && (a[23:12] <= sh_stop[w][11:0]);
                else
                    ok = (a[31:16] == 16'h0) && (a[15:0] >= sh_start[w])
                         && (a[15:0] <= sh_stop[w]);
            end
            if (ok) begin
                if (n == 0) begin
                    eh = 1; ei = 3'(w); ec = cm; ew = sh_attr[w][2]; et = sh_attr[w][1:0];
                end
                n++;
            end
        end
    endtask

    task automatic compare(input string tag, input logic [31:0] a,
                           input logic eh, input logic [2:0] ei, input logic ec,
                           input logic ew, input logic [1:0] et, input logic eo);
        checks++;
        if ({hit, hit_idx, card_is_mem, data_wide, timer_sel, overlap_err} !==
            {eh, ei, ec, ew, et, eo}) begin
            fails++;
            $display("FAIL %s addr=%h: got hit=%b idx=%0d cm=%b w=%b t=%0d ovl=%b expected hit=%b idx=%0d cm=%b w=%b t=%0d ovl=%b",
                     tag, a, hit, hit_idx, card_is_mem, data_wide, timer_sel, overlap_err,
                     eh, ei, ec, ew, et, eo);
        end
    endtask

    task automatic do_req(input logic [31:0] a, input logic m, input string tag);
        logic eh, ec, ew, eo;
        logic [2:0] ei;
        logic [1:0] et;
        int n;
        model(a, m, eh, ei, ec, ew, et, n);
        eo = exp_ovl | (n > 1);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_is_mem = m;
        @(negedge clk);
        req_valid = 0;
        compare(tag, a, eh, ei, ec, ew, et, eo);
        exp_ovl = eo;
    endtask

    // Shadow update follows the select map of R11
    task automatic shadow(input int sel, input logic [15:0] d);
        int w, o;
        case (sel)
            0: sh_en   = d[6:0];
            1: sh_ovr  = d[6:0];
            2: sh_bus  = d[6:0];
            3: sh_card = d[6:0];
            4: exp_ovl = 0;
            default: begin
                w = (sel - 8) / 4;
                o = (sel - 8) % 4;
                if (o == 0) sh_start[w] = d;
                if (o == 1) sh_stop[w]  = d;
                if (o == 2) sh_upper[w] = d[7:0];
                if (o == 3) sh_attr[w]  = d[2:0];
            end
        endcase
    endtask

    task automatic wr(input int sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = 6'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        shadow(sel, d);
    endtask

    task automatic set_win(input int w, input logic [15:0] s, input logic [15:0] e,
                           input logic [7:0] u);
        wr(8 + 4*w, s);
        wr(9 + 4*w, e);
        wr(10 + 4*w, {8'h0, u});
        wr(11 + 4*w, 16'((w & 3) | ((w & 1) << 2)));
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < NW; w++) begin
            logic rm;
            rm = sh_ovr[w] ? sh_bus[w] : (w < 5);
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 2; k++)
                    for (int u = 0; u < 2; u++)
                        for (int c = 0; c < 2; c++) begin
                            logic [31:0] a;
                            logic [11:0] pg;
                            logic [15:0] lo, hi;
                            if (rm) begin
                                pg = (p == 0) ? sh_start[w][11:0] - 12'd1 :
                                     (p == 1) ? sh_start[w][11:0] :
                                     (p == 2) ? sh_stop[w][11:0]  : sh_stop[w][11:0] + 12'd1;
                                a = {sh_upper[w] ^ 8'(u), pg, (k != 0) ? 12'hFFF : 12'h000};
                            end else begin
                                lo = (p == 0) ? sh_start[w] - 16'd1 :
                                     (p == 1) ? sh_start[w] :
                                     (p == 2) ? sh_stop[w]  : sh_stop[w] + 16'd1;
                                hi = (u == 0) ? 16'h0 : ((k != 0) ? 16'h8000 : 16'h0001);
                                a = {hi, lo};
                            end
                            do_req(a, c[0], tag);
                        end
        end
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            sh_start[w] = 0; sh_stop[w] = 0; sh_upper[w] = 0; sh_attr[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        compare("R1 reset", 32'h0, 0, 0, 0, 0, 0, 0);
        do_req(32'h0000_0000, 1, "R1 no hit after reset");
        do_req(32'h0000_0000, 0, "R1 no hit after reset");

        // Configuration A: default roles
        set_win(0, 16'h0010, 16'h001F, 8'h00);
        set_win(1, 16'h0100, 16'h0100, 8'h12);
        set_win(2, 16'h0200, 16'h02FF, 8'h12);
        set_win(3, 16'h0FFE, 16'h0FFF, 8'hFF);
        set_win(4, 16'h0000, 16'h0000, 8'h80);
        set_win(5, 16'h03F0, 16'h03F7, 8'h00);
        set_win(6, 16'h1000, 16'h10FF, 8'h00);
        // R3: programmed but not yet enabled
        do_req(32'h0001_0000, 1, "R3 disabled");
        do_req(32'h0000_03F0, 0, "R3 disabled");
        wr(0, 16'h0077);   // window 3 stays disabled
        sweep("R3/R4/R5/R6/R8 default sweep");

        // Configuration B: overrides (R7)
        set_win(0, 16'h2000, 16'h20FF, 8'h00);
        wr(10 + 4*5, 16'h0055);
        wr(3, 16'h0001);   // card side: window 0 memory, window 5 I/O
        wr(2, 16'h0020);   // bus side: window 0 I/O, window 5 memory
        wr(1, 16'h0021);   // override windows 0 and 5
        wr(0, 16'h007F);
        sweep("R7/R8 override sweep");
        do_req(32'h0000_2080, 0, "R7 io-bus mem-card");
        do_req(32'h553F_3000, 1, "R7 mem-bus io-card");

        // R10: write and request on the same edge
        begin
            logic eh, ec, ew, eo;
            logic [2:0] ei;
            logic [1:0] et;
            int n;
            model(32'h1210_0000, 1, eh, ei, ec, ew, et, n);
            eo = exp_ovl | (n > 1);
            @(negedge clk);
            wr_en = 1; wr_sel = 6'(10 + 4*1); wr_data = 16'h0034;
            req_valid = 1; req_addr = 32'h1210_0000; req_is_mem = 1;
            @(negedge clk);
            wr_en = 0; req_valid = 0;
            shadow(10 + 4*1, 16'h0034);
            compare("R10 same-edge write uses old value", 32'h1210_0000, eh, ei, ec, ew, et, eo);
            exp_ovl = eo;
        end
        do_req(32'h3410_0000, 1, "R10 new value seen");
        do_req(32'h1210_0000, 1, "R10 old value gone");

        // R9: overlap, priority and sticky flag
        set_win(2, 16'h0100, 16'h0100, 8'h34);
        do_req(32'h3410_0ABC, 1, "R9 lowest index wins");
        do_req(32'h0000_0000, 1, "R9 flag sticky");
        wr(4, 16'h0000);
        compare("R9 flag cleared", 32'h0, 0, 0, 0, 0, 0, 0);
        do_req(32'h0000_1000, 0, "R9 single hit no flag");

        report();
    end

endmodule